// File: doc/BRIEF.md
# Inverted-Feedback Stress Pattern Generator

This block produces a stream of pseudo-random 32-bit data words for exercising a memory array under stress. It keeps one 32-bit state register. The state is set from a seed word, and each advance request steps it forward. The registered state is the data word offered to the consumer. The consumer, such as a write-data path or a compare path, typically loads the same seed on both the write side and the read-back side, so the two sides replay the same sequence.

A single shift step moves the state one place toward bit 0. The bit that enters at the top is the inverse of the exclusive-OR of state bits 0, 1, 2 and 22, which corresponds to the polynomial x^32 + x^22 + x^2 + x + 1. One advance applies 32 such steps back to back, all within a single clock, so that every bit of the output word is fresh. Because the feedback is inverted, the state that never moves is all-ones, and an all-zero seed is a valid starting point.

Top module: `stress_pattern_gen`

## Requirements
- R1: When `rst` is high at a rising clock edge, `pattern` is 32'h0000_0000 after that edge.
- R2: When `seed_load` is high at a rising edge and `rst` is low, `pattern` equals `seed_val` after that edge.
- R3: When `seed_load` and `advance` are both high at the same edge, the seed is loaded and no stepping is applied.
- R4: When `advance` is high, `seed_load` is low and `rst` is low, `pattern` after the edge is the previous `pattern` taken through exactly 32 single steps.
- R5: When `rst`, `seed_load` and `advance` are all low, `pattern` keeps its value.
- R6: A single step takes state s to {f, s[31:1]}, where f = ~(s[0] ^ s[1] ^ s[2] ^ s[22]).
- R7: An advance from the all-ones state leaves the state at all-ones, and any other state changes on an advance.
- R8: An all-zero seed is legal: an advance from 32'h0000_0000 gives a non-zero word that follows R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, clears the state |
| seed_load | input | 1 | Load `seed_val` into the state; wins over `advance` |
| seed_val | input | 32 | Seed word |
| advance | input | 1 | Apply one 32-step advance to the state |
| pattern | output | 32 | Current state, used as the data word |

## Verification
The assertions assume that `rst` is driven to a known level from the first clock edge. They also assume that `seed_load` and `advance` are never unknown while reset is low. The stimulus drives every input on the falling edge from the start of simulation, so each input is already settled at the next rising edge. The "state always changes" property on an advance holds only when the state is not all-ones. The stimulus therefore reaches the all-ones state through directed seeds, where the fixed-point property applies instead. Random seeds, and the walk from a zero seed, stay off that state because the sequence has a single lock-up point.

// File: rtl/stress_lfsr_pkg.sv
package stress_lfsr_pkg;

    // State width and number of single steps per advance
    localparam int unsigned STATE_W   = 32;
    localparam int unsigned ADV_STEPS = 32;

    // Feedback taps; the step behaviour depends on these exact positions
    localparam int unsigned TAP_P0 = 0;
    localparam int unsigned TAP_P1 = 1;
    localparam int unsigned TAP_P2 = 2;
    localparam int unsigned TAP_P3 = 22;

    typedef logic [STATE_W-1:0] state_t;

    // Operation chosen for the state register in one cycle
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SEED  = 2'd1,
        OP_STEP  = 2'd2,
        OP_CLEAR = 2'd3
    } lfsr_op_e;

    // Decoded control bundle
    typedef struct packed {
        lfsr_op_e op;
        state_t   seed;
    } lfsr_ctrl_t;

    // Inverted feedback bit of a state
    function automatic logic inv_feedback(input state_t s);
        return ~(s[TAP_P0] ^ s[TAP_P1] ^ s[TAP_P2] ^ s[TAP_P3]);
    endfunction

endpackage

// File: rtl/lfsr_single_step.sv
module lfsr_single_step
    import stress_lfsr_pkg::*;
(
    input  state_t cur_state,
    output state_t nxt_state
);
    logic fb_bit;

    assign fb_bit    = inv_feedback(cur_state);
    assign nxt_state = {fb_bit, cur_state[STATE_W-1:1]};
endmodule

// File: rtl/lfsr_advance_chain.sv
module lfsr_advance_chain
    import stress_lfsr_pkg::*;
#(
    parameter int unsigned STEPS = ADV_STEPS
) (
    input  state_t from_state,
    output state_t to_state
);
    localparam int unsigned NODES = STEPS + 1;

    state_t node [NODES];

    assign node[0] = from_state;

    for (genvar g = 0; g < STEPS; g++) begin : g_step
        lfsr_single_step u_step (
            .cur_state (node[g]),
            .nxt_state (node[g+1])
        );
    end

    assign to_state = node[STEPS];
endmodule

// File: rtl/lfsr_op_decode.sv
module lfsr_op_decode
    import stress_lfsr_pkg::*;
(
    input  logic       rst,
    input  logic       seed_load,
    input  logic       advance,
    input  state_t     seed_val,
    output lfsr_ctrl_t ctrl
);
    // Priority: reset, then seed load, then advance
    always_comb begin
        ctrl.seed = seed_val;
        if (rst)
            ctrl.op = OP_CLEAR;
        else if (seed_load)
            ctrl.op = OP_SEED;
        else if (advance)
            ctrl.op = OP_STEP;
        else
            ctrl.op = OP_HOLD;
    end
endmodule

// File: rtl/stress_pattern_gen.sv
module stress_pattern_gen
    import stress_lfsr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                seed_load,
    input  logic [STATE_W-1:0]  seed_val,
    input  logic                advance,
    output logic [STATE_W-1:0]  pattern
);
    lfsr_ctrl_t ctrl;
    state_t     state_q;
    state_t     stepped;
    state_t     state_d;

    lfsr_op_decode u_dec (
        .rst       (rst),
        .seed_load (seed_load),
        .advance   (advance),
        .seed_val  (seed_val),
        .ctrl      (ctrl)
    );

    lfsr_advance_chain #(.STEPS(ADV_STEPS)) u_chain (
        .from_state (state_q),
        .to_state   (stepped)
    );

    always_comb begin
        unique case (ctrl.op)
            OP_CLEAR: state_d = '0;
            OP_SEED:  state_d = ctrl.seed;
            OP_STEP:  state_d = stepped;
            default:  state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign pattern = state_q;
endmodule

// File: rtl/stress_pattern_gen_chk.sv
module stress_pattern_gen_chk
    import stress_lfsr_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               seed_load,
    input logic [STATE_W-1:0] seed_val,
    input logic               advance,
    input logic [STATE_W-1:0] pattern
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (pattern == '0));

    assert_seed_taken_R2: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> (pattern == $past(seed_val)));

    // R3: a simultaneous advance must not disturb the loaded seed
    assert_seed_wins_R3: assert property (@(posedge clk) disable iff (rst)
        (seed_load && advance) |=> (pattern == $past(seed_val)));

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!seed_load && !advance) |=> $stable(pattern));

    assert_lockup_R7: assert property (@(posedge clk) disable iff (rst)
        (advance && !seed_load && (pattern == '1)) |=> (pattern == '1));

    assert_moves_R4: assert property (@(posedge clk) disable iff (rst)
        (advance && !seed_load && (pattern != '1)) |=> !$stable(pattern));

    assert_zero_legal_R8: assert property (@(posedge clk) disable iff (rst)
        (advance && !seed_load && (pattern == '0)) |=> (pattern != '0));
endmodule

bind stress_pattern_gen stress_pattern_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .seed_load (seed_load),
    .seed_val  (seed_val),
    .advance   (advance),
    .pattern   (pattern)
);

// File: tb/stress_pattern_gen_tb.sv
module stress_pattern_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        seed_load = 1'b0;
    logic [31:0] seed_val = '0;
    logic        advance = 1'b0;
    logic [31:0] pattern;

    int unsigned n_vec  = 0;
    int unsigned n_miss = 0;
    bit          done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    stress_pattern_gen dut_i (
        .clk       (clk),
        .rst       (rst),
        .seed_load (seed_load),
        .seed_val  (seed_val),
        .advance   (advance),
        .pattern   (pattern)
    );

    // Reference single step (R6)
    function automatic logic [31:0] ref_step(input logic [31:0] s);
        logic b;
        b = 1'b1 ^ s[0] ^ s[1] ^ s[2] ^ s[22];
        return (s >> 1) | ({31'd0, b} << 31);
    endfunction

    // Reference advance: 32 steps (R4)
    function automatic logic [31:0] ref_adv(input logic [31:0] s);
        logic [31:0] t;
        t = s;
        for (int i = 0; i < 32; i++) t = ref_step(t);
        return t;
    endfunction

    function automatic logic [31:0] ref_next(input logic r, input logic ld,
                                             input logic ad, input logic [31:0] sd,
                                             input logic [31:0] cur);
        if (r) return 32'h0;
        if (ld) return sd;
        if (ad) return ref_adv(cur);
        return cur;
    endfunction

    task automatic check(input string req, input logic [31:0] exp);
        n_vec++;
        if (pattern !== exp) begin
            n_miss++;
            $display("FAIL %s: pattern=%h expected=%h", req, pattern, exp);
        end
    endtask

    // Drive at falling edge, result observed at the following falling edge
    task automatic apply(input logic r, input logic ld, input logic ad,
                         input logic [31:0] sd, input string req,
                         inout logic [31:0] exp);
        rst = r; seed_load = ld; advance = ad; seed_val = sd;
        exp = ref_next(r, ld, ad, sd, exp);
        @(negedge clk);
        check(req, exp);
    endtask

    initial begin
        logic [31:0] exp;
        logic [31:0] prev;
        void'($urandom(32'd20240611));
        exp = 32'h0;
        @(negedge clk);
        // R1: reset state
        apply(1'b1, 1'b0, 1'b1, 32'hDEAD_BEEF, "R1", exp);
        apply(1'b1, 1'b1, 1'b0, 32'h1234_5678, "R1", exp);
        // R2: seed load
        apply(1'b0, 1'b1, 1'b0, 32'hA5A5_0F0F, "R2", exp);
        // R5: hold
        apply(1'b0, 1'b0, 1'b0, 32'hFFFF_0000, "R5", exp);
        // R3: load beats advance
        apply(1'b0, 1'b1, 1'b1, 32'h0BAD_CAFE, "R3", exp);
        // R4/R6: advance against reference steps
        apply(1'b0, 1'b0, 1'b1, 32'h0, "R4", exp);
        apply(1'b0, 1'b0, 1'b1, 32'h0, "R6", exp);
        // R7: all-ones lock-up
        apply(1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF, "R7", exp);
        apply(1'b0, 1'b0, 1'b1, 32'h0, "R7", exp);
        check("R7", 32'hFFFF_FFFF);
        // R7: one bit off all-ones still moves
        apply(1'b0, 1'b1, 1'b0, 32'hFFFF_FFFE, "R2", exp);
        prev = exp;
        apply(1'b0, 1'b0, 1'b1, 32'h0, "R7", exp);
        n_vec++;
        if (pattern == prev) begin
            n_miss++;
            $display("FAIL R7: pattern=%h expected!=%h", pattern, prev);
        end
        // R8: zero seed is legal
        apply(1'b0, 1'b1, 1'b0, 32'h0, "R8", exp);
        apply(1'b0, 1'b0, 1'b1, 32'h0, "R8", exp);
        n_vec++;
        if (pattern == 32'h0) begin
            n_miss++;
            $display("FAIL R8: pattern=%h expected!=%h", pattern, 32'h0);
        end
        for (int k = 0; k < 20; k++) apply(1'b0, 1'b0, 1'b1, 32'h0, "R8", exp);

        // Constrained random mix
        for (int k = 0; k < 3000; k++) begin
            int unsigned sel;
            logic r, ld, ad;
            logic [31:0] sd;
            sel = $urandom_range(99);
            r   = (sel < 3);
            ld  = (sel >= 3 && sel < 18) || (sel >= 90 && sel < 95);
            ad  = (sel >= 18 && sel < 80) || (sel >= 90);
            sd  = $urandom;
            if (sel == 97) sd = 32'hFFFF_FFFF;
            if (sel == 98) sd = 32'h0;
            if (r)            apply(r, ld, ad, sd, "R1", exp);
            else if (ld && ad) apply(r, ld, ad, sd, "R3", exp);
            else if (ld)      apply(r, ld, ad, sd, "R2", exp);
            else if (ad)      apply(r, ld, ad, sd, "R4", exp);
            else              apply(r, ld, ad, sd, "R5", exp);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_miss++;
            $display("FAIL watchdog: pattern=%h expected=done", pattern);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end
endmodule